// File: doc/BRIEF.md
# Palette Host Write Port

This block gives a host processor register-level access to eight colour palettes, each holding 256 entries. Every entry carries a 9-bit colour and a one-bit priority flag. The eight palettes form four layers with two banks each: character, bitmap, sprite and tile. The host reaches the block through four registers. The host selects one with `host_sel` and writes it with a single-cycle `host_wr` strobe. `host_rdata` shows the selected register at all times.

An entry can be written in two ways. A single-byte write stores an 8-bit colour and derives the lowest blue bit from it. A two-byte write stores the full 9-bit colour and, for bitmap palettes only, a priority flag. When a write completes, the index can step to the next entry by itself. Every completed entry write also appears for one cycle on a registered write port (`pw_en`, `pw_addr`, `pw_data`), which feeds the palette RAM of the display pipeline. The block keeps a copy of the entries internally so that the host can read them back. Four control bits go to the layer mixer: one banked-palette choice each for the sprite, bitmap and character layers, and one flag for an extended attribute mode.

Top module: `pal_host_if`

## Requirements
- R1: After reset, the index reads 0, the control register reads 0, `pw_en` is low, and `disp_sel_sprite`, `disp_sel_bitmap`, `disp_sel_char` and `ext_attr_en` are all low. The sequencer expects a first byte.
- R2: A write with `host_sel`=0 loads the index, and reading `host_sel`=0 returns it.
- R3: A write with `host_sel`=2 takes its byte as RRRGGGBB. It stores that byte as colour bits 8:1, sets colour bit 0 to the OR of byte bits 1:0, and clears the priority flag. On the next cycle `pw_en` is high for one cycle, with `pw_addr`={control bits 6:4, index} and `pw_data`={priority, RRRGGGBB, low blue}.
- R4: After each completed entry write the index increments by one, wrapping from 255 to 0. Setting control bit 7 to 1 suppresses the increment.
- R5: The first write with `host_sel`=3 only holds its byte. It produces no `pw_en` pulse and leaves the index unchanged.
- R6: The next write with `host_sel`=3 stores the held byte as colour bits 8:1 and its own bit 0 as colour bit 0, and raises `pw_en` one cycle later. Its bit 7 is stored as the priority flag only when control bits 5:4 are 01 (bitmap); for any other layer the flag is stored as 0.
- R7: Reads have no side effects. Holding `host_sel` with no write keeps the index unchanged. Reading `host_sel`=2 returns colour bits 8:1 of the addressed entry. Reading `host_sel`=3 returns {priority, 000000, colour bit 0}.
- R8: Control bits 6:4 pick the palette that is accessed. Bit 6 picks the bank and bits 5:4 pick the layer (00 character, 01 bitmap, 10 sprite, 11 tile). Each of the eight palettes keeps its own entries. Writing the control register does not move the index.
- R9: A write with `host_sel`=1 loads the control register, which reads back unchanged. Bit 3 drives `disp_sel_sprite`, bit 2 drives `disp_sel_bitmap`, bit 1 drives `disp_sel_char`, and bit 0 drives `ext_attr_en`.
- R10: An index write or a single-byte colour write makes the sequencer discard a held first byte, so the next `host_sel`=3 write is taken as a first byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_sel | input | 2 | Register select: 0 index, 1 control, 2 8-bit colour, 3 9-bit colour |
| host_wr | input | 1 | Single-cycle write strobe for the selected register |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Read data of the selected register |
| pw_en | output | 1 | Palette RAM write enable, one cycle per completed entry |
| pw_addr | output | 11 | Palette RAM address {bank, layer, index} |
| pw_data | output | 10 | Palette RAM data {priority, RRRGGGBB, low blue} |
| disp_sel_sprite | output | 1 | Sprite layer uses the second palette |
| disp_sel_bitmap | output | 1 | Bitmap layer uses the second palette |
| disp_sel_char | output | 1 | Character layer uses the second palette |
| ext_attr_en | output | 1 | Extended attribute mode enable |

## Verification
The assertions assume that `host_wr` lasts one cycle per register access and that `host_sel` and `host_wdata` are steady while `host_wr` is high. They also assume the host does not write during reset. The bench drives all inputs on the falling edge and drops `host_wr` after exactly one rising edge. It moves `host_sel` to the register it wants to read only after the write has ended. Each expected value in the vector table comes from the previous rows alone. The table reads back only entries that it has written first.

// File: rtl/pal_pkg.sv
// Package: shared register codes and the palette entry layout for the
// palette host write port. Assumes an 8-bit host data bus.
package pal_pkg;

    localparam int HOST_W  = 8;
    localparam int BANK_W  = 3;
    localparam int ENTRY_W = 10;

    // Host register select codes
    typedef enum logic [1:0] {
        REG_INDEX = 2'd0,
        REG_CTRL  = 2'd1,
        REG_COL8  = 2'd2,
        REG_COL9  = 2'd3
    } pal_reg_e;

    // Layer code that owns the priority flag
    localparam logic [1:0] LAYER_BITMAP = 2'b01;

    // One stored palette entry
    typedef struct packed {
        logic       prio;
        logic [7:0] rgb;
        logic       blo;
    } pal_entry_t;

endpackage

// File: rtl/pal_ctrl_regs.sv
// Module: index and control registers of the palette host port.
// Holds the entry index and the control byte, loads them from host
// writes and steps the index when the sequencer reports a finished
// entry. Assumes at most one of the load/step inputs is active per cycle.
module pal_ctrl_regs
    import pal_pkg::*;
#(
    parameter int IDX_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_idx,
    input  logic              load_ctrl,
    input  logic              step_idx,
    input  logic [HOST_W-1:0] wdata,
    output logic [IDX_W-1:0]  idx_q,
    output logic [HOST_W-1:0] ctrl_q
);

    // Index register: host load or post-write increment with wrap
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q <= '0;
        end else if (load_idx) begin
            idx_q <= wdata[IDX_W-1:0];
        end else if (step_idx) begin
            idx_q <= idx_q + 1'b1;
        end
    end

    // Control register: plain host load
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else if (load_ctrl) begin
            ctrl_q <= wdata;
        end
    end

endmodule

// File: rtl/pal_seq.sv
// Module: write sequencer for palette entries.
// Turns single-byte and two-byte colour writes into one entry commit.
// A two-byte write holds the first byte until the second arrives; an
// index write or single-byte write discards a held byte. Assumes the
// write strobes are mutually exclusive.
module pal_seq
    import pal_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_col8,
    input  logic              wr_col9,
    input  logic              wr_idx,
    input  logic              prio_ok,
    input  logic              auto_off,
    input  logic [HOST_W-1:0] wdata,
    output logic              commit,
    output pal_entry_t        commit_entry,
    output logic              step
);

    logic              second_q;
    logic [HOST_W-1:0] held_q;

    // Phase tracking: remember whether a first byte is held
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            second_q <= 1'b0;
        end else if (wr_idx || wr_col8) begin
            second_q <= 1'b0;
        end else if (wr_col9) begin
            second_q <= !second_q;
        end
    end

    // First-byte holding register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held_q <= '0;
        end else if (wr_col9 && !second_q) begin
            held_q <= wdata;
        end
    end

    // Entry build: single-byte form or completed two-byte form
    always_comb begin
        commit       = 1'b0;
        commit_entry = '0;
        if (wr_col8) begin
            commit            = 1'b1;
            commit_entry.prio = 1'b0;
            commit_entry.rgb  = wdata;
            commit_entry.blo  = wdata[1] | wdata[0];
        end else if (wr_col9 && second_q) begin
            commit            = 1'b1;
            commit_entry.prio = prio_ok & wdata[7];
            commit_entry.rgb  = held_q;
            commit_entry.blo  = wdata[0];
        end
    end

    // Index step request after a finished entry
    assign step = commit && !auto_off;

endmodule

// File: rtl/pal_store.sv
// Module: palette entry store and registered RAM write port.
// Keeps a copy of all palettes for host readback and presents each
// committed entry one cycle later on the outgoing write port.
// Assumes ADDR_W covers NUM_PAL * DEPTH entries.
module pal_store
    import pal_pkg::*;
#(
    parameter int NUM_PAL = 8,
    parameter int IDX_W   = 8,
    localparam int DEPTH  = 1 << IDX_W,
    localparam int TOTAL  = NUM_PAL * DEPTH,
    localparam int ADDR_W = $clog2(TOTAL)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              commit,
    input  logic [ADDR_W-1:0] addr,
    input  pal_entry_t        entry,
    output pal_entry_t        rd_entry,
    output logic              pw_en,
    output logic [ADDR_W-1:0] pw_addr,
    output logic [ENTRY_W-1:0] pw_data
);

    pal_entry_t mem [TOTAL];

    // Entry array update on commit
    always_ff @(posedge clk) begin
        if (commit) begin
            mem[addr] <= entry;
        end
    end

    // Registered write port toward the palette RAM
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pw_en   <= 1'b0;
            pw_addr <= '0;
            pw_data <= '0;
        end else begin
            pw_en <= commit;
            if (commit) begin
                pw_addr <= addr;
                pw_data <= entry;
            end
        end
    end

    // Readback of the addressed entry
    assign rd_entry = mem[addr];

endmodule

// File: rtl/pal_host_if.sv
// Module: palette host write port top.
// Decodes host register accesses, composes the palette address from the
// control selector and index, multiplexes read data and drives the
// display palette-select outputs. Assumes single-cycle write strobes.
module pal_host_if
    import pal_pkg::*;
#(
    parameter int IDX_W   = 8,
    localparam int NUM_PAL = 1 << BANK_W,
    localparam int ADDR_W  = BANK_W + IDX_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [1:0]          host_sel,
    input  logic                host_wr,
    input  logic [HOST_W-1:0]   host_wdata,
    output logic [HOST_W-1:0]   host_rdata,
    output logic                pw_en,
    output logic [ADDR_W-1:0]   pw_addr,
    output logic [ENTRY_W-1:0]  pw_data,
    output logic                disp_sel_sprite,
    output logic                disp_sel_bitmap,
    output logic                disp_sel_char,
    output logic                ext_attr_en
);

    logic              wr_idx, wr_ctrl, wr_col8, wr_col9;
    logic [IDX_W-1:0]  cur_index;
    logic [HOST_W-1:0] ctrl_q;
    logic              commit, step;
    pal_entry_t        commit_entry;
    pal_entry_t        rd_entry;
    logic [BANK_W-1:0] pal_sel;
    logic [ADDR_W-1:0] ent_addr;

    // Write strobe decode per register
    always_comb begin
        wr_idx  = host_wr && (host_sel == REG_INDEX);
        wr_ctrl = host_wr && (host_sel == REG_CTRL);
        wr_col8 = host_wr && (host_sel == REG_COL8);
        wr_col9 = host_wr && (host_sel == REG_COL9);
    end

    // Palette selector {bank, layer} and full entry address
    assign pal_sel  = ctrl_q[6:4];
    assign ent_addr = {pal_sel, cur_index};

    pal_ctrl_regs #(.IDX_W(IDX_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_idx  (wr_idx),
        .load_ctrl (wr_ctrl),
        .step_idx  (step),
        .wdata     (host_wdata),
        .idx_q     (cur_index),
        .ctrl_q    (ctrl_q)
    );

    pal_seq u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_col8      (wr_col8),
        .wr_col9      (wr_col9),
        .wr_idx       (wr_idx),
        .prio_ok      (pal_sel[1:0] == LAYER_BITMAP),
        .auto_off     (ctrl_q[7]),
        .wdata        (host_wdata),
        .commit       (commit),
        .commit_entry (commit_entry),
        .step         (step)
    );

    pal_store #(.NUM_PAL(NUM_PAL), .IDX_W(IDX_W)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .commit   (commit),
        .addr     (ent_addr),
        .entry    (commit_entry),
        .rd_entry (rd_entry),
        .pw_en    (pw_en),
        .pw_addr  (pw_addr),
        .pw_data  (pw_data)
    );

    // Read data multiplexer; reads have no side effects
    always_comb begin
        host_rdata = '0;
        unique case (host_sel)
            REG_INDEX: host_rdata[IDX_W-1:0] = cur_index;
            REG_CTRL:  host_rdata = ctrl_q;
            REG_COL8:  host_rdata = rd_entry.rgb;
            REG_COL9:  host_rdata = {rd_entry.prio, 6'b0, rd_entry.blo};
            default:   host_rdata = '0;
        endcase
    end

    // Display palette choices toward the layer mixer
    assign disp_sel_sprite = ctrl_q[3];
    assign disp_sel_bitmap = ctrl_q[2];
    assign disp_sel_char   = ctrl_q[1];
    assign ext_attr_en     = ctrl_q[0];

endmodule

// File: rtl/pal_host_if_chk.sv
// Module: assertion checker for the palette host write port, bound to
// the top. Assumes single-cycle host write strobes.
module pal_host_if_chk
    import pal_pkg::*;
#(
    parameter int IDX_W  = 8,
    parameter int ADDR_W = 11
) (
    input logic                clk,
    input logic                rst_n,
    input logic [1:0]          host_sel,
    input logic                host_wr,
    input logic [HOST_W-1:0]   host_wdata,
    input logic                pw_en,
    input logic [ADDR_W-1:0]   pw_addr,
    input logic [ENTRY_W-1:0]  pw_data,
    input logic [IDX_W-1:0]    idx,
    input logic [HOST_W-1:0]   ctrl
);

    assert_idx_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && host_sel == REG_INDEX) |=> idx == $past(host_wdata[IDX_W-1:0]));

    assert_col8_pack_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (pw_en && $past(host_wr && host_sel == REG_COL8))
            |-> (pw_data[0] == (pw_data[2] | pw_data[1])) && !pw_data[9]);

    assert_autoinc_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && host_sel == REG_COL8 && !ctrl[7]) |=> idx == $past(idx) + 1'b1);

    assert_inc_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && host_sel == REG_COL8 && ctrl[7]) |=> $stable(idx));

    assert_port_source_R5: assert property (@(posedge clk) disable iff (!rst_n)
        pw_en |-> $past(host_wr && host_sel[1]));

    assert_prio_layer_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (pw_en && pw_addr[IDX_W+1:IDX_W] != LAYER_BITMAP) |-> !pw_data[9]);

    assert_read_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !host_wr |=> $stable(idx));

    assert_ctrl_load_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && host_sel == REG_CTRL) |=> ctrl == $past(host_wdata));

endmodule

bind pal_host_if pal_host_if_chk #(.IDX_W(IDX_W), .ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .host_sel   (host_sel),
    .host_wr    (host_wr),
    .host_wdata (host_wdata),
    .pw_en      (pw_en),
    .pw_addr    (pw_addr),
    .pw_data    (pw_data),
    .idx        (cur_index),
    .ctrl       (ctrl_q)
);

// File: tb/pal_host_if_tb_top.sv
// Bench: vector table walk plus directed tests for the palette host port.
module pal_host_if_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  host_sel = 2'd0;
    logic        host_wr = 1'b0;
    logic [7:0]  host_wdata = 8'h00;
    logic [7:0]  host_rdata;
    logic        pw_en;
    logic [10:0] pw_addr;
    logic [9:0]  pw_data;
    logic        disp_sel_sprite, disp_sel_bitmap, disp_sel_char, ext_attr_en;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #10 clk = !clk;

    pal_host_if dut_i (
        .clk             (clk),
        .rst_n           (rst_n),
        .host_sel        (host_sel),
        .host_wr         (host_wr),
        .host_wdata      (host_wdata),
        .host_rdata      (host_rdata),
        .pw_en           (pw_en),
        .pw_addr         (pw_addr),
        .pw_data         (pw_data),
        .disp_sel_sprite (disp_sel_sprite),
        .disp_sel_bitmap (disp_sel_bitmap),
        .disp_sel_char   (disp_sel_char),
        .ext_attr_en     (ext_attr_en)
    );

    localparam logic [1:0] S_IDX = 2'd0, S_CTL = 2'd1, S_C8 = 2'd2, S_C9 = 2'd3;
    localparam int NV = 36;
    // Row: {write select, write data, read select, expected read data}
    localparam logic [19:0] VEC [NV] = '{
        {S_IDX, 8'h10, S_IDX, 8'h10},  // 0  R2
        {S_C8,  8'hE5, S_IDX, 8'h11},  // 1  R4
        {S_IDX, 8'h10, S_C8,  8'hE5},  // 2  R3
        {S_IDX, 8'h10, S_C9,  8'h01},  // 3  R3
        {S_C9,  8'h48, S_IDX, 8'h10},  // 4  R5
        {S_C9,  8'h80, S_IDX, 8'h11},  // 5  R6
        {S_IDX, 8'h10, S_C8,  8'h48},  // 6  R6
        {S_IDX, 8'h10, S_C9,  8'h00},  // 7  R6 no flag on character layer
        {S_CTL, 8'h10, S_CTL, 8'h10},  // 8  R8
        {S_IDX, 8'hFF, S_IDX, 8'hFF},  // 9  R2
        {S_C9,  8'h1C, S_IDX, 8'hFF},  // 10 R5
        {S_C9,  8'h81, S_IDX, 8'h00},  // 11 R4 wrap
        {S_IDX, 8'hFF, S_C9,  8'h81},  // 12 R6 flag kept on bitmap
        {S_IDX, 8'hFF, S_C8,  8'h1C},  // 13 R6
        {S_CTL, 8'h90, S_CTL, 8'h90},  // 14 R9
        {S_C8,  8'h02, S_IDX, 8'hFF},  // 15 R4 increment off
        {S_IDX, 8'hFF, S_C9,  8'h01},  // 16 R3 flag cleared
        {S_CTL, 8'hA0, S_CTL, 8'hA0},  // 17 R8
        {S_C8,  8'h33, S_C8,  8'h33},  // 18 R8
        {S_CTL, 8'hC0, S_CTL, 8'hC0},  // 19 R8
        {S_C8,  8'h77, S_C8,  8'h77},  // 20 R8
        {S_CTL, 8'hA0, S_C8,  8'h33},  // 21 R8
        {S_CTL, 8'h80, S_IDX, 8'hFF},  // 22 R8
        {S_IDX, 8'h10, S_C8,  8'h48},  // 23 R8
        {S_CTL, 8'h00, S_CTL, 8'h00},  // 24 R9
        {S_IDX, 8'h20, S_IDX, 8'h20},  // 25 R2
        {S_C9,  8'h55, S_IDX, 8'h20},  // 26 R5
        {S_IDX, 8'h20, S_IDX, 8'h20},  // 27 R10
        {S_C9,  8'h66, S_IDX, 8'h20},  // 28 R10
        {S_C9,  8'h01, S_IDX, 8'h21},  // 29 R10
        {S_IDX, 8'h20, S_C8,  8'h66},  // 30 R10
        {S_C9,  8'h11, S_IDX, 8'h20},  // 31 R5
        {S_C8,  8'h22, S_IDX, 8'h21},  // 32 R10
        {S_C9,  8'h44, S_IDX, 8'h21},  // 33 R10
        {S_C9,  8'h00, S_IDX, 8'h22},  // 34 R10
        {S_IDX, 8'h21, S_C8,  8'h44}   // 35 R10
    };

    function automatic string req_of(int i);
        case (i)
            0, 9, 25:                       return "R2";
            2, 3, 16:                       return "R3";
            1, 11, 15:                      return "R4";
            4, 10, 26, 31:                  return "R5";
            5, 6, 7, 12, 13:                return "R6";
            8, 17, 18, 19, 20, 21, 22, 23:  return "R8";
            14, 24:                         return "R9";
            default:                        return "R10";
        endcase
    endfunction

    task automatic check(input string req, input string what,
                         input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // One host write; returns just after the falling edge that ends it
    task automatic host_write(input logic [1:0] sel, input logic [7:0] data);
        @(negedge clk);
        host_sel   = sel;
        host_wdata = data;
        host_wr    = 1'b1;
        @(negedge clk);
        host_wr    = 1'b0;
    endtask

    task automatic read_reg(input logic [1:0] sel, output logic [7:0] val);
        host_sel = sel;
        #1;
        val = host_rdata;
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin : main
        logic [7:0] rv;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1 reset state
        read_reg(S_IDX, rv); check("R1", "index", {8'h0, rv}, 16'h0);
        read_reg(S_CTL, rv); check("R1", "control", {8'h0, rv}, 16'h0);
        check("R1", "pw_en", {15'h0, pw_en}, 16'h0);
        check("R1", "selects", {12'h0, disp_sel_sprite, disp_sel_bitmap,
              disp_sel_char, ext_attr_en}, 16'h0);

        // Vector table walk
        for (int i = 0; i < NV; i++) begin
            host_write(VEC[i][19:18], VEC[i][17:10]);
            read_reg(VEC[i][9:8], rv);
            check(req_of(i), $sformatf("vector %0d", i), {8'h0, rv}, {8'h0, VEC[i][7:0]});
        end

        // R3 write port content and timing (tile layer, first bank)
        host_write(S_CTL, 8'h30);
        host_write(S_IDX, 8'h40);
        host_write(S_C8, 8'hA6);
        #1;
        check("R3", "pw_en", {15'h0, pw_en}, 16'h1);
        check("R3", "pw_addr", {5'h0, pw_addr}, 16'h0340);
        check("R3", "pw_data", {6'h0, pw_data}, 16'h014D);
        @(negedge clk); #1;
        check("R3", "pw_en one cycle", {15'h0, pw_en}, 16'h0);

        // R5 first byte gives no port pulse; R6 second byte with flag on bitmap bank 2
        host_write(S_CTL, 8'h50);
        host_write(S_IDX, 8'h05);
        host_write(S_C9, 8'h12);
        #1;
        check("R5", "no pulse after first byte", {15'h0, pw_en}, 16'h0);
        host_write(S_C9, 8'h81);
        #1;
        check("R6", "pw_en", {15'h0, pw_en}, 16'h1);
        check("R6", "pw_addr", {5'h0, pw_addr}, 16'h0505);
        check("R6", "pw_data", {6'h0, pw_data}, 16'h0225);

        // R7 holding a read select does not move the index
        host_sel = S_C8;
        repeat (5) @(negedge clk);
        read_reg(S_IDX, rv); check("R7", "index after reads", {8'h0, rv}, 16'h06);

        // R9 display select outputs
        host_write(S_CTL, 8'h0F); #1;
        check("R9", "selects 0F", {12'h0, disp_sel_sprite, disp_sel_bitmap,
              disp_sel_char, ext_attr_en}, 16'hF);
        host_write(S_CTL, 8'h0A); #1;
        check("R9", "selects 0A", {12'h0, disp_sel_sprite, disp_sel_bitmap,
              disp_sel_char, ext_attr_en}, 16'hA);

        // R1 reset in mid-run clears a held first byte and the registers
        host_write(S_C9, 8'h3C);
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        read_reg(S_IDX, rv); check("R1", "index after reset", {8'h0, rv}, 16'h0);
        read_reg(S_CTL, rv); check("R1", "control after reset", {8'h0, rv}, 16'h0);
        host_write(S_C9, 8'h3C); #1;
        check("R1", "sequencer expects first byte", {15'h0, pw_en}, 16'h0);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule